// File: doc/BRIEF.md
# Output Impedance Update Scheduler

This block decides in which clock cycle a new output-driver calibration code may take effect. An external digital comparator supplies a target code every cycle. The scheduler holds the code that the drivers actually use. It walks that code toward the target one step at a time, and only when two conditions hold. First, a free-running spacing counter must show that enough cycles have passed since the last change. Second, the current cycle must not be driving the data pins. A cycle drives the pins only when it is a read with output enable active, so deselected cycles and cycles with output enable high are both safe.

A second counter tracks cycles that are not reads since reset. It raises a sticky settled flag once enough of them have been seen, which tells the rest of the chip that the driver strength has converged. A mode input selects a fixed minimum-impedance setting. In that mode the applied code is forced to all ones and stepping stops. The spacing, settle count and code width are parameters. With the defaults the spacing is 32 cycles, the settle count is 1024 non-read cycles and codes are 6 bits wide. Mid-scale is the code with only its top bit set.

Top module: `zq_update_sched`

## Requirements
- R1: In normal mode, two code changes are at least GAP rising edges apart. The first change after reset comes no earlier than the GAP-th rising edge.
- R2: The spacing counter advances on every clock edge, whatever `rd_cycle`, `oe_n` and `fixed_mode` are. Once GAP edges have passed, an update is not delayed any further by how many driving cycles came before.
- R3: A code change in normal mode happens only at an edge where the cycle is not driving. A cycle is driving when `rd_cycle`=1 and `oe_n`=0. A deselected cycle (`rd_cycle`=0) and a cycle with `oe_n`=1 both permit an update.
- R4: After a run of driving read cycles longer than GAP, with a target that differs from the code, the code changes at the first edge where `oe_n` is 1.
- R5: Each normal-mode change moves `code` by exactly one, toward `target_code`. When the two are equal, the code holds and no strobe occurs.
- R6: `upd_stb` is 1 for exactly the one cycle that follows an edge at which `code` changed, and 0 otherwise.
- R7: `settled` rises after the SETTLE-th edge at which `rd_cycle` was 0, counted since reset. Read cycles do not reset this count. Once high, the flag stays high until reset.
- R8: While `fixed_mode`=1, the next edge forces `code` to all ones and suppresses stepping toward the target. A forced change also restarts the spacing count.
- R9: Reset sets `code` to mid-scale (only the top bit set), clears the spacing and settle counts, and holds `upd_stb` and `settled` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_cycle | input | 1 | The current cycle is a selected read |
| oe_n | input | 1 | Output enable state, 1 means outputs disabled |
| fixed_mode | input | 1 | Selects the fixed minimum-impedance setting |
| target_code | input | CODE_W | Code requested by the external comparator |
| code | output | CODE_W | Code applied to the output drivers |
| upd_stb | output | 1 | One-cycle pulse after the applied code changes |
| settled | output | 1 | Sticky flag: enough non-read cycles have passed since reset |

## Verification
The hardest case to reach from the ports is an update that is owed but keeps being blocked. The spacing window has expired and the target differs, yet every cycle is a driving read. The bench builds exactly that: it lets the window expire with the target equal to the code, then moves the target and holds reads with outputs enabled for longer than the window. It checks that no strobe appears during the run. It then releases once through output enable and once through deselection, and checks that the step lands at that very edge. Around these directed cases, a pseudo-random sweep on a small configuration compares every output in every cycle against an arithmetic model that is run from the requirements.

// File: rtl/zq_sched_pkg.sv
package zq_sched_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } zq_step_e;
endpackage

// File: rtl/zq_sat_counter.sv
// Up-counter that stops at LIMIT; synchronous clear has priority.
module zq_sat_counter #(
   parameter int LIMIT = 31,
   parameter int W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt,
   output logic         full
);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("zq_sat_counter: LIMIT must be at least 1");
   end

   assign full = (cnt == LIM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && !full)
         cnt <= cnt + W'(1);
   end
endmodule

// File: rtl/zq_step_decider.sv
// Chooses the direction of the next single-step move.
module zq_step_decider
   import zq_sched_pkg::*;
#(
   parameter int CODE_W = 6
) (
   input  logic [CODE_W-1:0] cur_code,
   input  logic [CODE_W-1:0] want_code,
   output zq_step_e          step
);
   always_comb begin
      if (want_code > cur_code)
         step = STEP_UP;
      else if (want_code < cur_code)
         step = STEP_DOWN;
      else
         step = STEP_HOLD;
   end
endmodule

// File: rtl/zq_code_reg.sv
// Holds the applied code and produces the change strobe.
module zq_code_reg
   import zq_sched_pkg::*;
#(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              force_min,
   input  logic [CODE_W-1:0] min_code,
   input  logic              apply,
   input  zq_step_e          step,
   output logic [CODE_W-1:0] code,
   output logic              strobe,
   output logic              changing
);
   localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] nxt;

   always_comb begin
      nxt = code;
      if (force_min)
         nxt = min_code;
      else if (apply) begin
         case (step)
            STEP_UP:   nxt = code + CODE_W'(1);
            STEP_DOWN: nxt = code - CODE_W'(1);
            default:   nxt = code;
         endcase
      end
   end

   assign changing = (nxt != code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code   <= MID;
         strobe <= 1'b0;
      end else begin
         code   <= nxt;
         strobe <= changing;
      end
   end
endmodule

// File: rtl/zq_update_sched.sv
module zq_update_sched
   import zq_sched_pkg::*;
#(
   parameter int CODE_W       = 6,
   parameter int GAP          = 32,
   parameter int SETTLE       = 1024,
   parameter bit MIN_IMP_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_cycle,
   input  logic              oe_n,
   input  logic              fixed_mode,
   input  logic [CODE_W-1:0] target_code,
   output logic [CODE_W-1:0] code,
   output logic              upd_stb,
   output logic              settled
);
   localparam int GAP_LIM = GAP - 1;
   localparam int GAP_W   = $clog2(GAP_LIM + 1);
   localparam int SET_W   = $clog2(SETTLE + 1);

   if (CODE_W < 2) begin : g_bad_width
      $error("zq_update_sched: CODE_W must be at least 2");
   end
   if (GAP < 2) begin : g_bad_gap
      $error("zq_update_sched: GAP must be at least 2");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("zq_update_sched: SETTLE must be at least 1");
   end

   logic [CODE_W-1:0] min_code;
   if (MIN_IMP_HIGH) begin : g_min_ones
      assign min_code = '1;
   end else begin : g_min_zero
      assign min_code = '0;
   end

   logic             drive_now;
   logic             gap_ready;
   logic             apply;
   logic             changing;
   logic [GAP_W-1:0] gap_cnt;
   logic [SET_W-1:0] set_cnt;
   zq_step_e         step;

   assign drive_now = rd_cycle & ~oe_n;
   assign apply     = gap_ready & ~drive_now & ~fixed_mode & (step != STEP_HOLD);

   zq_sat_counter #(.LIMIT(GAP_LIM), .W(GAP_W)) u_gap (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (changing),
      .inc  (1'b1),
      .cnt  (gap_cnt),
      .full (gap_ready)
   );

   zq_sat_counter #(.LIMIT(SETTLE), .W(SET_W)) u_settle (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (1'b0),
      .inc  (~rd_cycle),
      .cnt  (set_cnt),
      .full (settled)
   );

   zq_step_decider #(.CODE_W(CODE_W)) u_dec (
      .cur_code (code),
      .want_code(target_code),
      .step     (step)
   );

   zq_code_reg #(.CODE_W(CODE_W)) u_code (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_min(fixed_mode),
      .min_code (min_code),
      .apply    (apply),
      .step     (step),
      .code     (code),
      .strobe   (upd_stb),
      .changing (changing)
   );
endmodule

// File: rtl/zq_update_sched_chk.sv
module zq_update_sched_chk #(
   parameter int CODE_W       = 6,
   parameter int GAP          = 32,
   parameter bit MIN_IMP_HIGH = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_cycle,
   input logic              oe_n,
   input logic              fixed_mode,
   input logic [CODE_W-1:0] code,
   input logic              upd_stb,
   input logic              settled
);
   localparam int CW = $clog2(GAP + 1);
   localparam logic [CW-1:0] CLIM = CW'(GAP);
   localparam logic [CODE_W-1:0] MINC = {CODE_W{MIN_IMP_HIGH}};

   // edges since the previous visible strobe (or reset), saturating at GAP
   logic [CW-1:0] since;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since <= '0;
      else if (upd_stb)
         since <= CW'(1);
      else if (since != CLIM)
         since <= since + CW'(1);
   end

   a_r1_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !$past(fixed_mode)) |-> (since >= CLIM));

   a_r3_quiet_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !$past(fixed_mode)) |-> !($past(rd_cycle) && !$past(oe_n)));

   a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_stb && !$past(fixed_mode)) |->
         ((code == $past(code) + CODE_W'(1)) || (code == $past(code) - CODE_W'(1))));

   a_r6_strobe_match: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb == (code != $past(code)));

   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(settled));

   a_r8_forced: assert property (@(posedge clk) disable iff (!rst_n)
      $past(fixed_mode) |-> (code == MINC));
endmodule

bind zq_update_sched zq_update_sched_chk #(
   .CODE_W(CODE_W), .GAP(GAP), .MIN_IMP_HIGH(MIN_IMP_HIGH)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_cycle(rd_cycle), .oe_n(oe_n),
   .fixed_mode(fixed_mode), .code(code), .upd_stb(upd_stb), .settled(settled)
);

// File: tb/zq_update_sched_test.sv
`timescale 1ns/1ps
module zq_update_sched_test;
   localparam int CODE_W = 4;
   localparam int GAP    = 8;
   localparam int SETTLE = 20;
   localparam int MAXC   = (1 << CODE_W) - 1;
   localparam int MIDC   = 1 << (CODE_W - 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_cycle = 1'b0;
   logic              oe_n = 1'b0;
   logic              fixed_mode = 1'b0;
   logic [CODE_W-1:0] target_code = '0;
   logic [CODE_W-1:0] code;
   logic              upd_stb;
   logic              settled;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   int m_code, m_gap, m_sc, since;
   bit m_stb;

   always #2.5 clk = ~clk;

   zq_update_sched #(.CODE_W(CODE_W), .GAP(GAP), .SETTLE(SETTLE)) uut (
      .clk(clk), .rst_n(rst_n), .rd_cycle(rd_cycle), .oe_n(oe_n),
      .fixed_mode(fixed_mode), .target_code(target_code),
      .code(code), .upd_stb(upd_stb), .settled(settled)
   );

   task automatic chk(input string req, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", req, got, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rd_cycle = 1'b0; oe_n = 1'b0; fixed_mode = 1'b0;
      target_code = CODE_W'(MIDC);
      m_code = MIDC; m_gap = 0; m_sc = 0; m_stb = 1'b0; since = 0;
      @(negedge clk); @(negedge clk);
      chk("R9 reset code", int'(code), MIDC);
      chk("R9 reset strobe", int'(upd_stb), 0);
      chk("R9 reset settled", int'(settled), 0);
      rst_n = 1'b1;
   endtask

   task automatic cyc(input bit rd, input bit oe, input bit fx, input int tgt);
      bit drv;
      rd_cycle = rd; oe_n = oe; fixed_mode = fx; target_code = CODE_W'(tgt);
      drv = rd && !oe;
      if (fx) begin
         if (m_code != MAXC) begin m_code = MAXC; m_stb = 1'b1; m_gap = 0; end
         else begin m_stb = 1'b0; if (m_gap < GAP - 1) m_gap++; end
      end else if (m_gap == GAP - 1 && !drv && tgt != m_code) begin
         m_code = (tgt > m_code) ? m_code + 1 : m_code - 1;
         m_stb = 1'b1; m_gap = 0;
      end else begin
         m_stb = 1'b0; if (m_gap < GAP - 1) m_gap++;
      end
      if (!rd && m_sc < SETTLE) m_sc++;
      @(posedge clk); @(negedge clk);
      since++;
      chk("R3 R5 R8 code", int'(code), m_code);
      chk("R6 strobe", int'(upd_stb), int'(m_stb));
      chk("R7 settled", int'(settled), int'(m_sc == SETTLE));
      if (upd_stb) begin
         if (!fx) chk("R1 spacing", int'(since >= GAP), 1);
         since = 0;
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung run expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      int stb_seen;
      do_reset();

      // ramp to top from idle cycles (R1 R5)
      for (int i = 0; i < 80; i++) cyc(1'b0, 1'b0, 1'b0, MAXC);
      chk("R5 reached target", int'(code), MAXC);
      // ramp down with outputs disabled reads
      for (int i = 0; i < 130; i++) cyc(1'b1, 1'b1, 1'b0, 0);
      chk("R5 reached zero", int'(code), 0);

      // owed update blocked by driving reads (R2 R3 R4)
      do_reset();
      for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 1'b0, MIDC);
      for (int i = 0; i < 3 * GAP; i++) cyc(1'b1, 1'b0, 1'b0, MIDC + 3);
      chk("R4 still mid", int'(code), MIDC);
      cyc(1'b1, 1'b1, 1'b0, MIDC + 3);
      chk("R4 oe high releases", int'(upd_stb), 1);
      chk("R2 no extra wait", int'(code), MIDC + 1);
      for (int i = 0; i < 3 * GAP; i++) cyc(1'b1, 1'b0, 1'b0, MIDC + 3);
      cyc(1'b0, 1'b0, 1'b0, MIDC + 3);
      chk("R3 deselect releases", int'(upd_stb), 1);

      // hold when equal (R5)
      stb_seen = 0;
      for (int i = 0; i < 4 * GAP; i++) begin
         cyc(1'b0, 1'b1, 1'b0, int'(code));
         stb_seen += int'(upd_stb);
      end
      chk("R5 hold no strobe", stb_seen, 0);

      // fixed mode (R8)
      cyc(1'b1, 1'b0, 1'b1, 0);
      chk("R8 forced all ones", int'(code), MAXC);
      stb_seen = 0;
      for (int i = 0; i < 3 * GAP; i++) begin
         cyc(1'b0, 1'b1, 1'b1, 0);
         stb_seen += int'(upd_stb);
      end
      chk("R8 no stepping", stb_seen, 0);
      cyc(1'b0, 1'b1, 1'b0, 0);
      chk("R8 release steps down", int'(code), MAXC - 1);

      // settle counting with reads interleaved (R7)
      do_reset();
      for (int i = 0; i < SETTLE - 1; i++) begin
         cyc(1'b0, 1'b0, 1'b0, MIDC);
         cyc(1'b1, 1'b0, 1'b0, MIDC);
      end
      chk("R7 not yet settled", int'(settled), 0);
      cyc(1'b0, 1'b0, 1'b0, MIDC);
      chk("R7 settled at count", int'(settled), 1);
      for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, MIDC);
      chk("R7 sticky", int'(settled), 1);

      // pseudo-random sweep
      do_reset();
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (lf[15:13] == 3'd0) target_code = lf[7:4];
         cyc(lf[0], lf[1] & lf[2], (i % 700) > 640, int'(target_code));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule